// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block turns a slow step clock into the four gate drive levels of a unipolar two-phase stepping motor. Each qualified rising edge of the step input moves a 3-bit phase position one notch around an eight-state ring. A mode input picks between full-step drive, where two windings are always energised, and half-step drive, where single-winding states sit between the two-winding states. A direction input picks forward or reverse rotation. An active-low hold input cuts off all four gates and sends the ring back to its starting point. When the hold input is released, the first pattern driven is winding A together with winding B-bar.

All four control inputs arrive from outside the system clock domain, so each passes through a two-flop synchronizer. A step pulse counts only after it has stayed high for a configurable number of system-clock cycles. Mode and direction are sampled when the synchronized step input rises, and that snapshot governs the step.

Top module: `step_phase_seq`

## Requirements
- R1: After the system reset `rst` is released with `hold_n` high, the outputs settle within 4 clock cycles to A and B-bar on, i.e. {phase_a, phase_a_bar, phase_b, phase_b_bar} = 4'b1001.
- R2: While `hold_n` is low, all four phase outputs are 0 from the third clock edge onwards. When `hold_n` returns high, the first pattern is 4'b1001 again, whatever position was held before.
- R3: Step pulses applied while `hold_n` is low do not move the position. After release the outputs show 4'b1001.
- R4: With `half_sel` = 0 and `dir_rev` = 0, successive steps from 4'b1001 give 4'b1010, 4'b0110, 4'b0101, 4'b1001 (A+B, A-bar+B, A-bar+B-bar, A+B-bar).
- R5: With `half_sel` = 1 and `dir_rev` = 0, successive steps from 4'b1001 give 1000, 1010, 0010, 0110, 0100, 0101, 0001, 1001.
- R6: With `dir_rev` = 1, the same ring is walked in the reverse order in either mode.
- R7: `half_sel` and `dir_rev` are taken at the rising edge of the synchronized step input. Changes made while the step pulse is high do not affect that step.
- R8: In full-step mode on a single-winding position, a step moves to the neighbouring two-winding position in the chosen direction.
- R9: A step pulse shorter than MIN_PULSE system-clock cycles leaves the outputs unchanged. Outputs change only in response to a qualified step or to `hold_n`.
- R10: At most two outputs are ever high, and never a winding together with its own complement (A with A-bar, or B with B-bar).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for sampling |
| rst | input | 1 | Synchronous active-high system reset |
| step_in | input | 1 | Asynchronous step clock; each long-enough rising edge moves one step |
| half_sel | input | 1 | 0 selects full-step, 1 selects half-step drive |
| dir_rev | input | 1 | 0 selects forward rotation, 1 selects reverse rotation |
| hold_n | input | 1 | Active-low cutoff; turns all gates off and returns to the start position |
| phase_a | output | 1 | Gate drive for winding A |
| phase_a_bar | output | 1 | Gate drive for winding A-bar |
| phase_b | output | 1 | Gate drive for winding B |
| phase_b_bar | output | 1 | Gate drive for winding B-bar |

## Verification
The hardest state to reach is a single-winding position in full-step mode. The ports give no direct way to load one. The stimulus first takes an odd number of half-step steps, then switches the mode low and steps in each direction, so that the snap to the neighbouring two-winding position is checked both ways. A second awkward case flips mode and direction while a step pulse is still high, to show that the values sampled at the edge win. Finally, runt pulses one cycle short of the qualification length are sent to check that they are dropped.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

    localparam int POS_W   = 3;
    localparam int NUM_POS = 1 << POS_W;

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic a;
        logic a_bar;
        logic b;
        logic b_bar;
    } phase_vec_t;

    typedef struct packed {
        logic fire;
        logic half;
        logic rev;
    } step_cmd_t;

    localparam phase_vec_t PHASE_OFF = '{a: 1'b0, a_bar: 1'b0, b: 1'b0, b_bar: 1'b0};

    // Ring order: 0 A+Bb, 1 A, 2 A+B, 3 B, 4 Ab+B, 5 Ab, 6 Ab+Bb, 7 Bb
    function automatic phase_vec_t pos_to_phase(input pos_t p);
        phase_vec_t v;
        v.a     = (p == 3'd0) || (p == 3'd1) || (p == 3'd2);
        v.b     = (p == 3'd2) || (p == 3'd3) || (p == 3'd4);
        v.a_bar = (p == 3'd4) || (p == 3'd5) || (p == 3'd6);
        v.b_bar = (p == 3'd6) || (p == 3'd7) || (p == 3'd0);
        return v;
    endfunction

    function automatic pos_t advance_pos(input pos_t p, input logic half, input logic rev);
        pos_t stride;
        if (half || p[0]) stride = pos_t'(1);
        else              stride = pos_t'(2);
        if (rev) return p - stride;
        else     return p + stride;
    endfunction

endpackage

// File: rtl/step_sync.sv
module step_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/step_edge_qual.sv
module step_edge_qual
    import step_seq_pkg::*;
#(
    parameter int MIN_PULSE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      step_lvl,
    input  logic      half_lvl,
    input  logic      rev_lvl,
    output step_cmd_t cmd
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_PULSE - 1);

    logic             lvl_q;
    logic [CNT_W-1:0] hi_cnt;
    logic             cap_half;
    logic             cap_rev;
    logic             rise;

    assign rise = step_lvl && !lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= 1'b0;
            hi_cnt   <= '0;
            cap_half <= 1'b0;
            cap_rev  <= 1'b0;
            cmd      <= '0;
        end else begin
            lvl_q    <= step_lvl;
            cmd.fire <= 1'b0;
            if (!enable || !step_lvl) begin
                hi_cnt <= '0;
            end else if (rise) begin
                hi_cnt   <= CNT_W'(1);
                cap_half <= half_lvl;
                cap_rev  <= rev_lvl;
                if (MIN_PULSE <= 1) begin
                    cmd.fire <= 1'b1;
                    cmd.half <= half_lvl;
                    cmd.rev  <= rev_lvl;
                    hi_cnt   <= '0;
                end
            end else if (hi_cnt != '0) begin
                if (hi_cnt == LAST) begin
                    cmd.fire <= 1'b1;
                    cmd.half <= cap_half;
                    cmd.rev  <= cap_rev;
                    hi_cnt   <= '0;
                end else begin
                    hi_cnt <= hi_cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/step_pos_ctr.sv
module step_pos_ctr
    import step_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  step_cmd_t cmd,
    output pos_t      pos
);
    always_ff @(posedge clk) begin
        if (rst || !enable)  pos <= '0;
        else if (cmd.fire)   pos <= advance_pos(pos, cmd.half, cmd.rev);
    end
endmodule

// File: rtl/step_phase_drv.sv
module step_phase_drv
    import step_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  pos_t       pos,
    output phase_vec_t gates
);
    always_ff @(posedge clk) begin
        if (rst || !enable) gates <= PHASE_OFF;
        else                gates <= pos_to_phase(pos);
    end
endmodule

// File: rtl/step_phase_seq.sv
module step_phase_seq
    import step_seq_pkg::*;
#(
    parameter int MIN_PULSE   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic step_in,
    input  logic half_sel,
    input  logic dir_rev,
    input  logic hold_n,
    output logic phase_a,
    output logic phase_a_bar,
    output logic phase_b,
    output logic phase_b_bar
);
    localparam int N_IN = 4;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] sync_in;
    logic            run_ok;
    step_cmd_t       cmd;
    pos_t            pos;
    phase_vec_t      gates;

    assign raw_in = {hold_n, dir_rev, half_sel, step_in};
    assign run_ok = sync_in[3];

    step_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_in),
        .sync_out (sync_in)
    );

    step_edge_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .enable   (run_ok),
        .step_lvl (sync_in[0]),
        .half_lvl (sync_in[1]),
        .rev_lvl  (sync_in[2]),
        .cmd      (cmd)
    );

    step_pos_ctr u_pos (
        .clk    (clk),
        .rst    (rst),
        .enable (run_ok),
        .cmd    (cmd),
        .pos    (pos)
    );

    step_phase_drv u_drv (
        .clk    (clk),
        .rst    (rst),
        .enable (run_ok),
        .pos    (pos),
        .gates  (gates)
    );

    assign phase_a     = gates.a;
    assign phase_a_bar = gates.a_bar;
    assign phase_b     = gates.b;
    assign phase_b_bar = gates.b_bar;
endmodule

// File: rtl/step_phase_seq_chk.sv
module step_phase_seq_chk (
    input logic clk,
    input logic rst,
    input logic run_ok,
    input logic fire,
    input logic phase_a,
    input logic phase_a_bar,
    input logic phase_b,
    input logic phase_b_bar
);
    logic [3:0] outs;
    assign outs = {phase_a, phase_a_bar, phase_b, phase_b_bar};

    AST_NO_OPPOSED: assert property (@(posedge clk) disable iff (rst)
        !(phase_a && phase_a_bar) && !(phase_b && phase_b_bar)); // R10

    AST_TWO_MAX: assert property (@(posedge clk) disable iff (rst)
        $countones(outs) <= 2); // R10

    AST_HOLD_CUTOFF: assert property (@(posedge clk) disable iff (rst)
        !run_ok |=> (outs == 4'b0000)); // R2

    AST_RELEASE_START: assert property (@(posedge clk) disable iff (rst)
        $rose(run_ok) |=> (outs == 4'b1001)); // R2

    AST_STEP_ONLY: assert property (@(posedge clk) disable iff (rst)
        (run_ok && $past(run_ok) && $past(run_ok, 2) && (outs != $past(outs)))
        |-> $past(fire, 2)); // R9
endmodule

bind step_phase_seq step_phase_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .run_ok      (run_ok),
    .fire        (cmd.fire),
    .phase_a     (phase_a),
    .phase_a_bar (phase_a_bar),
    .phase_b     (phase_b),
    .phase_b_bar (phase_b_bar)
);

// File: tb/step_phase_seq_bench.sv
module step_phase_seq_bench;
    localparam int MINP = 16;

    logic clk = 1'b0;
    logic rst;
    logic step_in, half_sel, dir_rev, hold_n;
    logic phase_a, phase_a_bar, phase_b, phase_b_bar;

    always #10 clk = ~clk;

    step_phase_seq #(.MIN_PULSE(MINP)) u_step_phase_seq (
        .clk(clk), .rst(rst), .step_in(step_in), .half_sel(half_sel),
        .dir_rev(dir_rev), .hold_n(hold_n), .phase_a(phase_a),
        .phase_a_bar(phase_a_bar), .phase_b(phase_b), .phase_b_bar(phase_b_bar)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int mpos = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    function automatic logic [3:0] ring_pat(int p);
        case (p & 7)
            0: return 4'b1001;
            1: return 4'b1000;
            2: return 4'b1010;
            3: return 4'b0010;
            4: return 4'b0110;
            5: return 4'b0100;
            6: return 4'b0101;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic int model_next(int p, bit half, bit rev);
        int s;
        s = (half || (p % 2 == 1)) ? 1 : 2;
        return rev ? ((p - s + 8) % 8) : ((p + s) % 8);
    endfunction

    task automatic expect_out(string tag, logic [3:0] e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        repeat (4) @(negedge clk);
    endtask

    // monitor: pops expected items and compares with the outputs
    initial begin
        logic [3:0] act, e;
        string t;
        forever begin
            wait (exp_q.size() != 0);
            @(negedge clk);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            act = {phase_a, phase_a_bar, phase_b, phase_b_bar};
            checks++;
            if (act !== e) begin
                errors++;
                $display("FAIL %s: got %b expected %b", t, act, e);
            end
            checks++;
            if ((act[3] && act[2]) || (act[1] && act[0])) begin
                errors++;
                $display("FAIL R10: got %b expected no opposed pair", act);
            end
        end
    end

    task automatic pulse(int hi_len, bit half, bit rev, bit flip);
        @(negedge clk);
        half_sel = half;
        dir_rev  = rev;
        repeat (4) @(negedge clk);
        step_in = 1'b1;
        if (flip) begin
            repeat (6) @(negedge clk);
            half_sel = ~half;
            dir_rev  = ~rev;
            repeat (hi_len - 6) @(negedge clk);
        end else begin
            repeat (hi_len) @(negedge clk);
        end
        step_in = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic step(string tag, bit half, bit rev);
        pulse(MINP + 8, half, rev, 1'b0);
        mpos = model_next(mpos, half, rev);
        expect_out(tag, ring_pat(mpos));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; step_in = 1'b0; half_sel = 1'b0; dir_rev = 1'b0; hold_n = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        expect_out("R1 reset pattern", 4'b1001);

        for (int i = 0; i < 4; i++) step("R4 full forward", 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step("R6 full reverse", 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) step("R5 half forward", 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) step("R6 half reverse", 1'b1, 1'b1);

        step("R5 half to odd", 1'b1, 1'b0);
        step("R8 full from odd forward", 1'b0, 1'b0);
        step("R5 half to odd", 1'b1, 1'b0);
        step("R8 full from odd reverse", 1'b0, 1'b1);

        // R7: mode and direction flipped mid-pulse, edge values win
        pulse(MINP + 8, 1'b1, 1'b0, 1'b1);
        mpos = model_next(mpos, 1'b1, 1'b0);
        expect_out("R7 half fwd kept", ring_pat(mpos));
        pulse(MINP + 8, 1'b0, 1'b1, 1'b1);
        mpos = model_next(mpos, 1'b0, 1'b1);
        expect_out("R7 full rev kept", ring_pat(mpos));

        // R9: runt pulses ignored
        pulse(MINP - 1, 1'b0, 1'b0, 1'b0);
        expect_out("R9 runt ignored", ring_pat(mpos));
        pulse(2, 1'b1, 1'b1, 1'b0);
        expect_out("R9 short ignored", ring_pat(mpos));
        step("R9 qualified after runt", 1'b1, 1'b0);

        // R2 / R3: cutoff, steps ignored, restart at A+Bb
        @(negedge clk);
        hold_n = 1'b0;
        repeat (4) @(negedge clk);
        expect_out("R2 cutoff", 4'b0000);
        pulse(MINP + 8, 1'b1, 1'b0, 1'b0);
        expect_out("R3 step in hold", 4'b0000);
        hold_n = 1'b1;
        repeat (4) @(negedge clk);
        mpos = 0;
        expect_out("R3 release start", 4'b1001);
        step("R2 first after release", 1'b0, 1'b0);

        // R1: system reset from a non-start position
        step("R5 move off start", 1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        mpos = 0;
        expect_out("R1 reset again", 4'b1001);

        wait (exp_q.size() == 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule